// File: doc/BRIEF.md
# Symmetric Transposed-Form FIR Filter

This block is a fully parallel FIR filter that takes one sample per accepted transfer and produces one filtered result per accepted transfer. It uses the transposed structure. Every incoming sample is broadcast to all taps at once, and partial sums move one register per accepted sample toward the output, so the long adder tree of a direct-form filter never appears. The coefficient set is fixed at elaboration and must be symmetric. Only the first half of the coefficients, rounded up, is supplied. The block computes one product per distinct coefficient and sends it to both mirror positions of the chain. Mirror positions add the product for positive symmetry and subtract it for negative symmetry. Parameters select the tap count, which may be odd or even, and the symmetry sign.

Samples arrive on a valid/ready stream and results leave on a valid/ready stream. The output holds one registered result. A new sample is accepted only when that slot is empty or is being emptied in the same cycle. While the consumer holds `out_ready` low with a result pending, `in_ready` stays low and both the result and its valid flag stay frozen. After reset, the filter swallows the first NTAPS-1 accepted samples without producing a result. This fills the history of the chain. Each accepted sample after that yields exactly one result.

Top module: `fir_sym_transpose`

## Requirements
- R1: After a synchronous reset, `out_valid` is 0 and `in_ready` is 1, and the filter history is all zeros.
- R2: The result produced for accepted sample x(n) equals the sum over k = 0..NTAPS-1 of C[k]·x(n−k), with samples before reset taken as zero. The result is exact at the full width DATA_W + 16 + ceil(log2 NTAPS).
- R3: The first NTAPS−1 samples accepted after reset produce no result. Each later accepted sample produces exactly one result.
- R4: With `NEG_SYM` = 0, C[NTAPS−1−n] = C[n]. C[j] for j below ceil(NTAPS/2) is the signed 16-bit field at bits [16·j +: 16] of `HALF_COEFS`.
- R5: With `NEG_SYM` = 1, C[NTAPS−1−n] = −C[n] for every n where the two taps are distinct.
- R6: With an odd NTAPS, the middle coefficient C[(NTAPS−1)/2] is taken from its own field. It is never negated, even under negative symmetry.
- R7: `in_ready` is 1 exactly when `out_valid` is 0 or `out_ready` is 1. While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` keep their values into the next cycle.
- R8: Full-scale inputs (−32768 and 32767 sustained) with extreme coefficients (−32768) give exact results, with no wrap.
- R9: Cycles with `in_valid` low do not advance the filter. After an idle cycle with `out_ready` high, `out_valid` is 0, and the next result is the same as it would be without the gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Sample will be taken this cycle if offered |
| in_data | input | DATA_W | Signed input sample |
| out_valid | output | 1 | Result pending in the output slot |
| out_ready | input | 1 | Consumer takes the pending result |
| out_data | output | DATA_W+16+ceil(log2 NTAPS) | Signed filtered result |

## Verification
The hardest condition to reach from the ports is a mirror tap getting the wrong sign or the wrong partner while the output still looks plausible. The bench therefore runs four filters side by side on the same stream: even and odd length, each with positive and negative symmetry. Their coefficient halves are deliberately unequal, so any swapped, unsigned or mis-paired product shifts the result. An impulse placed right after the fill period shows each coefficient at the output in turn. Full-scale steps push the accumulators to their extreme values. Random gaps on both sides of the stream, together with a mid-run reset, test that stalls never advance the chain and that the fill count starts again from zero.

// File: rtl/fir_sym_pkg.sv
package fir_sym_pkg;
  localparam int COEF_W   = 16;
  localparam int MAX_HALF = 8;

  function automatic int half_count(input int taps);
    return (taps + 1) / 2;
  endfunction

  function automatic int acc_width(input int dw, input int taps);
    return dw + COEF_W + $clog2(taps);
  endfunction
endpackage

// File: rtl/fir_sym_products.sv
// One multiplier per distinct coefficient; each product feeds both mirror taps.
module fir_sym_products
  import fir_sym_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int NTAPS  = 7,
  parameter logic [MAX_HALF*COEF_W-1:0] HALF_COEFS = '0,
  localparam int NHALF = half_count(NTAPS),
  localparam int PW    = DATA_W + COEF_W
) (
  input  logic signed [DATA_W-1:0]   sample,
  output logic [NHALF-1:0][PW-1:0]   prod
);
  logic signed [PW-1:0] sx;
  assign sx = PW'(sample);

  for (genvar j = 0; j < NHALF; j++) begin : g_mul
    logic signed [COEF_W-1:0] c;
    logic signed [PW-1:0]     cx;
    assign c  = HALF_COEFS[j*COEF_W +: COEF_W];
    assign cx = PW'(c);
    assign prod[j] = sx * cx;
  end
endmodule

// File: rtl/fir_sym_chain.sv
// Transposed partial-sum chain; mirror taps reuse the shared product.
module fir_sym_chain
  import fir_sym_pkg::*;
#(
  parameter int NTAPS   = 7,
  parameter int PW      = 32,
  parameter int ACC_W   = 35,
  parameter bit NEG_SYM = 1'b0,
  localparam int NHALF  = half_count(NTAPS)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      advance,
  input  logic [NHALF-1:0][PW-1:0]  prod,
  output logic signed [ACC_W-1:0]   tail
);
  logic signed [ACC_W-1:0] term [NTAPS];
  logic signed [ACC_W-1:0] acc  [NTAPS];

  for (genvar k = 0; k < NTAPS; k++) begin : g_term
    localparam int MIR  = (k < NHALF) ? k : NTAPS - 1 - k;
    localparam bit FLIP = NEG_SYM && (k >= NHALF);
    logic signed [ACC_W-1:0] ext;
    assign ext = ACC_W'($signed(prod[MIR]));
    if (FLIP) begin : g_sub
      assign term[k] = -ext;
    end else begin : g_add
      assign term[k] = ext;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NTAPS; i++) acc[i] <= '0;
    end else if (advance) begin
      acc[0] <= term[NTAPS-1];
      for (int i = 1; i < NTAPS; i++) acc[i] <= acc[i-1] + term[NTAPS-1-i];
    end
  end

  assign tail = acc[NTAPS-1];
endmodule

// File: rtl/fir_sym_ctrl.sv
// Stream handshake and fill tracking.
module fir_sym_ctrl #(
  parameter int NTAPS = 7,
  localparam int CW   = $clog2(NTAPS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic out_ready,
  output logic in_ready,
  output logic advance,
  output logic out_valid
);
  logic [CW-1:0] filled;
  logic          primed_next;

  assign in_ready    = !out_valid || out_ready;
  assign advance     = in_valid && in_ready;
  assign primed_next = filled >= CW'(NTAPS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      filled    <= '0;
      out_valid <= 1'b0;
    end else if (advance) begin
      if (filled != CW'(NTAPS)) filled <= filled + 1'b1;
      out_valid <= primed_next;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/fir_sym_transpose.sv
module fir_sym_transpose
  import fir_sym_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int NTAPS   = 7,
  parameter bit NEG_SYM = 1'b0,
  parameter logic [MAX_HALF*COEF_W-1:0] HALF_COEFS = {
    {(MAX_HALF-4){16'h0000}}, 16'h0100, 16'hFF80, 16'h0040, 16'h0010},
  localparam int NHALF = half_count(NTAPS),
  localparam int PW    = DATA_W + COEF_W,
  localparam int ACC_W = acc_width(DATA_W, NTAPS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic signed [DATA_W-1:0] in_data,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic signed [ACC_W-1:0] out_data
);
  logic                     advance;
  logic [NHALF-1:0][PW-1:0] prod;

  fir_sym_ctrl #(.NTAPS(NTAPS)) u_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .out_ready(out_ready),
    .in_ready(in_ready), .advance(advance), .out_valid(out_valid)
  );

  fir_sym_products #(.DATA_W(DATA_W), .NTAPS(NTAPS), .HALF_COEFS(HALF_COEFS)) u_prod (
    .sample(in_data), .prod(prod)
  );

  fir_sym_chain #(.NTAPS(NTAPS), .PW(PW), .ACC_W(ACC_W), .NEG_SYM(NEG_SYM)) u_chain (
    .clk(clk), .rst(rst), .advance(advance), .prod(prod), .tail(out_data)
  );
endmodule

// File: rtl/fir_sym_transpose_chk.sv
module fir_sym_transpose_chk #(
  parameter int NTAPS = 7,
  parameter int ACC_W = 35
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [ACC_W-1:0] out_data
);
  int seen;
  always_ff @(posedge clk) begin
    if (rst) seen <= 0;
    else if (in_valid && in_ready && seen < NTAPS) seen <= seen + 1;
  end

  a_r3_fill_before_output: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> seen >= NTAPS);

  a_r3_rise_on_accept: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(in_valid && in_ready));

  a_r7_stall_blocks_input: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  a_r7_hold_result: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r9_idle_drains: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && out_ready) |=> !out_valid);
endmodule

bind fir_sym_transpose fir_sym_transpose_chk #(.NTAPS(NTAPS), .ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/fir_sym_transpose_tb.sv
module fir_sym_transpose_tb;
  localparam int NCFG = 4;
  localparam int DW   = 16;
  localparam int AW   = 35;
  localparam int TAPS_T [NCFG] = '{8, 8, 7, 7};
  localparam bit NEG_T  [NCFG] = '{1'b0, 1'b1, 1'b0, 1'b1};
  localparam int HV [NCFG][4] = '{
    '{-32768, 1000, -32768, -300},
    '{120, -32768, 77, 32767},
    '{5, -9, 300, -32768},
    '{-32768, 44, -2000, 9}};

  function automatic logic [127:0] pack_half(input int c);
    logic [127:0] r;
    r = '0;
    for (int j = 0; j < 4; j++) r[j*16 +: 16] = 16'(HV[c][j]);
    return r;
  endfunction

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0, out_ready = 1'b0;
  logic signed [DW-1:0] in_data = '0;
  logic rdy [NCFG];
  logic ov  [NCFG];
  logic signed [AW-1:0] od [NCFG];

  always #10 clk = ~clk;

  for (genvar g = 0; g < NCFG; g++) begin : g_cfg
    fir_sym_transpose #(.DATA_W(DW), .NTAPS(TAPS_T[g]), .NEG_SYM(NEG_T[g]),
                        .HALF_COEFS(pack_half(g))) u_dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(rdy[g]),
      .in_data(in_data), .out_valid(ov[g]), .out_ready(out_ready),
      .out_data(od[g]));
  end

  int nchk = 0, nerr = 0;
  string ptag = "R1 reset";
  bit ev [NCFG];
  int cnt [NCFG];
  longint hist [NCFG][16];
  longint ed [NCFG];
  // requirement tags per configuration: R4 positive, R5 negative, R6 odd middle
  string ctag [NCFG] = '{"R2 R4 even", "R2 R5 even", "R2 R4 R6 odd", "R2 R5 R6 odd"};

  function automatic longint coef(input int c, input int k);
    int n, nh;
    n = TAPS_T[c];
    nh = (n + 1) / 2;
    if (k < nh) return HV[c][k];
    return NEG_T[c] ? -HV[c][n-1-k] : HV[c][n-1-k];
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s [%s] actual=%0d expected=%0d", req, ptag, act, exp);
    end
  endtask

  task automatic step(input bit r, input bit v, input int x, input bit ordy);
    @(negedge clk);
    for (int c = 0; c < NCFG; c++) begin
      check(rdy[c] == (!ev[c] || out_ready), "R7 in_ready", longint'(rdy[c]),
            longint'(!ev[c] || out_ready));
      check(ov[c] == ev[c], "R3 out_valid", longint'(ov[c]), longint'(ev[c]));
      if (ev[c] && ov[c]) check(longint'(od[c]) == ed[c], ctag[c], longint'(od[c]), ed[c]);
    end
    rst = r; in_valid = v; in_data = DW'(x); out_ready = ordy;
    for (int c = 0; c < NCFG; c++) begin
      if (r) begin
        ev[c] = 1'b0; cnt[c] = 0;
        for (int k = 0; k < 16; k++) hist[c][k] = 0;
      end else if (v && (!ev[c] || ordy)) begin
        for (int k = 15; k > 0; k--) hist[c][k] = hist[c][k-1];
        hist[c][0] = x;
        if (cnt[c] < TAPS_T[c]) cnt[c]++;
        ev[c] = cnt[c] >= TAPS_T[c];
        ed[c] = 0;
        for (int k = 0; k < TAPS_T[c]; k++) ed[c] += coef(c, k) * hist[c][k];
      end else if (ordy) begin
        ev[c] = 1'b0;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCFG; c++) begin
      ev[c] = 1'b0; cnt[c] = 0; ed[c] = 0;
      for (int k = 0; k < 16; k++) hist[c][k] = 0;
    end
    repeat (3) step(1, 0, 0, 0);
    ptag = "R1 reset";
    step(0, 0, 0, 1);
    for (int c = 0; c < NCFG; c++) begin
      check(ov[c] == 1'b0, "R1 out_valid", longint'(ov[c]), 0);
      check(rdy[c] == 1'b1, "R1 in_ready", longint'(rdy[c]), 1);
    end
    ptag = "R2 impulse after fill R3";
    repeat (7) step(0, 1, 0, 1);
    step(0, 1, 1, 1);
    repeat (10) step(0, 1, 0, 1);
    ptag = "R8 full-scale step";
    repeat (20) step(0, 1, -32768, 1);
    repeat (20) step(0, 1, 32767, 1);
    repeat (12) step(0, 1, -32768, 1);
    ptag = "R9 gaps";
    for (int i = 0; i < 300; i++)
      step(0, ($urandom_range(2) != 0), int'($urandom_range(65535)) - 32768, 1);
    ptag = "R7 backpressure";
    for (int i = 0; i < 400; i++)
      step(0, $urandom_range(1) == 1, int'($urandom_range(65535)) - 32768,
           $urandom_range(1) == 1);
    ptag = "R3 refill after reset";
    step(1, 0, 0, 1);
    step(1, 0, 0, 1);
    for (int i = 0; i < 14; i++) step(0, 1, 4000 - i * 611, 1);
    repeat (4) step(0, 0, 0, 1);
    step(0, 0, 0, 1);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule